// File: doc/BRIEF.md
# Configurable Parallel Prefix Adder

A purely combinational adder of parameterised width that splits its work into three steps. The first step turns each operand bit pair into a bit generate and a bit propagate term. The second step is a prefix network that merges these terms, stage by stage, into group terms for every span from a bit down to bit 0. The third step turns the group terms into carries and then into sum bits. The incoming carry is folded into the bit-0 generate term. As a result, the group generate ending at any bit is the carry into the next bit, and the group generate spanning the whole word is the carry-out.

A parameter chooses the shape of the prefix network. Three shapes are offered:
- Sklansky: minimum depth, with fanout that doubles at each stage.
- Brent-Kung: an up-sweep followed by a down-sweep, using few merge cells and 2·log2(N)−1 stages.
- Kogge-Stone: minimum depth with fanout of one per stage, at the cost of many merge cells.

The first and last steps are the same for every shape. The width must be a power of two and at least 2.

Top module: `ppa_adder`

## Requirements
- R1: For every input, {c_o, sum_o} equals a_i + b_i + c_i, taken as unsigned numbers with WIDTH+1 result bits.
- R2: The carry into bit i+1 equals g_i OR (p_i AND carry into bit i), where g_i = a_i[i] AND b_i[i], p_i = a_i[i] XOR b_i[i], and the carry into bit 0 is c_i. A carry entering at bit 0 therefore ripples through a run of propagating bits to the top.
- R3: The group propagate produced for bit i is the AND of the bit propagates of bits i down to 0. When every bit propagates (b_i = ~a_i), sum_o has every bit equal to NOT c_i, and c_o equals c_i.
- R4: c_o is the carry out of the most significant bit. With a_i all ones, b_i zero and c_i = 1, sum_o is 0 and c_o is 1.
- R5: TOPO selects the prefix network: 0 Sklansky, 1 Brent-Kung, 2 Kogge-Stone. All three give identical sum_o and c_o for every input.
- R6: Zero plus zero with c_i = 0 gives sum_o = 0 and c_o = 0.
- R7: With b_i = 0 and c_i = 0, sum_o equals a_i and c_o is 0.
- R8: All ones plus all ones with c_i = 1 gives sum_o all ones and c_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| c_o | output | 1 | Carry out of the top bit |

## Verification
The bench aims at the longest carry chains: all-ones plus a carry-in, and operands that propagate at every bit. A network with a missing or misplaced merge cell drops the carry partway along such a chain, so the upper sum bits stay stale. The identity and all-zero cases catch a carry-in that is folded in twice or leaks when it should be zero. The all-ones-plus-all-ones case catches a carry-out taken from the wrong span. All three network shapes run side by side on the same random and directed vectors, so a fault in just one shape shows up as a mismatch between them even on vectors where the arithmetic reference happens to agree.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

  typedef enum int {
    TOPO_SKLANSKY    = 0,
    TOPO_BRENT_KUNG  = 1,
    TOPO_KOGGE_STONE = 2
  } ppa_topo_e;

  function automatic int ppa_num_stages(ppa_topo_e topo, int lg);
    return (topo == TOPO_BRENT_KUNG) ? 2 * lg - 1 : lg;
  endfunction

  // Lower neighbour merged into bit at this stage; -1 means feedthrough.
  function automatic int ppa_partner(ppa_topo_e topo, int stg, int bit_idx, int lg);
    int d;
    int t;
    case (topo)
      TOPO_SKLANSKY: begin
        if (stg < lg) begin
          d = 1 << stg;
          if ((bit_idx & d) != 0) return (bit_idx & ~(d - 1)) - 1;
        end
      end
      TOPO_KOGGE_STONE: begin
        if (stg < lg) begin
          d = 1 << stg;
          if (bit_idx >= d) return bit_idx - d;
        end
      end
      default: begin
        if (stg < lg) begin
          d = 1 << stg;
          if (((bit_idx + 1) % (2 * d)) == 0) return bit_idx - d;
        end else begin
          t = 2 * lg - 2 - stg;
          d = 1 << t;
          if ((((bit_idx + 1) % (2 * d)) == d) && (bit_idx > d)) return bit_idx - d;
        end
      end
    endcase
    return -1;
  endfunction

endpackage

// File: rtl/ppa_pre.sv
module ppa_pre #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] g_bit_o,
  output logic [WIDTH-1:0] p_bit_o,
  output logic [WIDTH-1:0] g_net_o
);

  assign g_bit_o = a_i & b_i;
  assign p_bit_o = a_i ^ b_i;

  // carry-in acts as a generate at position -1, absorbed into bit 0
  always_comb begin
    g_net_o    = g_bit_o;
    g_net_o[0] = g_bit_o[0] | (p_bit_o[0] & c_i);
  end

endmodule

// File: rtl/ppa_merge.sv
module ppa_merge (
  input  logic g_hi_i,
  input  logic p_hi_i,
  input  logic g_lo_i,
  input  logic p_lo_i,
  output logic g_o,
  output logic p_o
);

  assign g_o = g_hi_i | (p_hi_i & g_lo_i);
  assign p_o = p_hi_i & p_lo_i;

endmodule

// File: rtl/ppa_network.sv
module ppa_network
  import ppa_pkg::*;
#(
  parameter int        WIDTH = 32,
  parameter ppa_topo_e TOPO  = TOPO_SKLANSKY
) (
  input  logic [WIDTH-1:0] g_i,
  input  logic [WIDTH-1:0] p_i,
  output logic [WIDTH-1:0] g_o,
  output logic [WIDTH-1:0] p_o
);

  localparam int LG   = $clog2(WIDTH);
  localparam int NSTG = ppa_num_stages(TOPO, LG);

  logic [WIDTH-1:0] g_s [NSTG+1];
  logic [WIDTH-1:0] p_s [NSTG+1];

  assign g_s[0] = g_i;
  assign p_s[0] = p_i;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      localparam int PT = ppa_partner(TOPO, s, b, LG);
      if (PT >= 0) begin : g_mrg
        ppa_merge u_merge (
          .g_hi_i(g_s[s][b]),
          .p_hi_i(p_s[s][b]),
          .g_lo_i(g_s[s][PT]),
          .p_lo_i(p_s[s][PT]),
          .g_o   (g_s[s+1][b]),
          .p_o   (p_s[s+1][b])
        );
      end else begin : g_thru
        assign g_s[s+1][b] = g_s[s][b];
        assign p_s[s+1][b] = p_s[s][b];
      end
    end
  end

  assign g_o = g_s[NSTG];
  assign p_o = p_s[NSTG];

  logic [WIDTH-1:0] p_and;
  always_comb begin
    p_and[0] = p_i[0];
    for (int i = 1; i < WIDTH; i++) p_and[i] = p_and[i-1] & p_i[i];
  end

  always_comb begin
    if (!$isunknown(p_i)) begin
      // R3
      group_prop_chk: assert (p_o == p_and)
        else $error("group propagate mismatch");
    end
  end

endmodule

// File: rtl/ppa_post.sv
module ppa_post #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] p_bit_i,
  input  logic [WIDTH-1:0] g_grp_i,
  input  logic             c_i,
  output logic [WIDTH:0]   carry_o,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o
);

  assign carry_o = {g_grp_i, c_i};
  assign sum_o   = p_bit_i ^ carry_o[WIDTH-1:0];
  assign c_o     = carry_o[WIDTH];

endmodule

// File: rtl/ppa_adder.sv
module ppa_adder
  import ppa_pkg::*;
#(
  parameter int        WIDTH = 32,
  parameter ppa_topo_e TOPO  = TOPO_SKLANSKY
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o
);

  logic [WIDTH-1:0] g_bit, p_bit, g_net;
  logic [WIDTH-1:0] g_grp, p_grp;
  logic [WIDTH:0]   carry;

  ppa_pre #(.WIDTH(WIDTH)) u_pre (
    .a_i    (a_i),
    .b_i    (b_i),
    .c_i    (c_i),
    .g_bit_o(g_bit),
    .p_bit_o(p_bit),
    .g_net_o(g_net)
  );

  ppa_network #(.WIDTH(WIDTH), .TOPO(TOPO)) u_net (
    .g_i(g_net),
    .p_i(p_bit),
    .g_o(g_grp),
    .p_o(p_grp)
  );

  ppa_post #(.WIDTH(WIDTH)) u_post (
    .p_bit_i(p_bit),
    .g_grp_i(g_grp),
    .c_i    (c_i),
    .carry_o(carry),
    .sum_o  (sum_o),
    .c_o    (c_o)
  );

  logic p_grp_unused;
  assign p_grp_unused = ^p_grp;

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i})) begin
      // R1
      add_result_chk: assert ({c_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i}))
        else $error("sum mismatch");
      // R3
      all_prop_chk: assert (!(&p_bit) || (c_o == c_i))
        else $error("full propagate carry mismatch");
      // R7
      identity_chk: assert ((b_i != '0) || c_i || ((sum_o == a_i) && !c_o))
        else $error("identity mismatch");
      for (int i = 0; i < WIDTH; i++) begin
        // R2
        ripple_chk: assert (carry[i+1] == (g_bit[i] | (p_bit[i] & carry[i])))
          else $error("carry recurrence broken at bit %0d", i);
      end
    end
  end

endmodule

// File: tb/tb_ppa_adder.sv
module tb_ppa_adder;
  import ppa_pkg::*;

  localparam int W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a, b;
  logic         cin;
  logic [W-1:0] s_sk, s_bk, s_ks;
  logic         c_sk, c_bk, c_ks;

  int total = 0;
  int bad   = 0;

  ppa_adder #(.WIDTH(W), .TOPO(TOPO_SKLANSKY)) dut (
    .a_i(a), .b_i(b), .c_i(cin), .sum_o(s_sk), .c_o(c_sk));
  ppa_adder #(.WIDTH(W), .TOPO(TOPO_BRENT_KUNG)) dut_bk (
    .a_i(a), .b_i(b), .c_i(cin), .sum_o(s_bk), .c_o(c_bk));
  ppa_adder #(.WIDTH(W), .TOPO(TOPO_KOGGE_STONE)) dut_ks (
    .a_i(a), .b_i(b), .c_i(cin), .sum_o(s_ks), .c_o(c_ks));

  function automatic logic [W:0] ref_add(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic chk(string req, logic [W:0] got, logic [W:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h (a=%h b=%h c=%b)", req, got, exp, a, b, cin);
    end
  endtask

  task automatic apply(string req, logic [W-1:0] x, logic [W-1:0] y, logic c, logic [W:0] exp);
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    chk(req, {c_sk, s_sk}, exp);
    chk(req, {c_bk, s_bk}, exp);
    chk(req, {c_ks, s_ks}, exp);
    chk("R5", {c_bk, s_bk}, {c_sk, s_sk});
    chk("R5", {c_ks, s_ks}, {c_sk, s_sk});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    logic [W-1:0] x, y;
    logic c;
    seed = 32'h1d2c3b4a;
    void'($urandom(seed));
    a = '0; b = '0; cin = 1'b0;

    apply("R6", '0, '0, 1'b0, '0);
    apply("R7", 16'h5a3c, '0, 1'b0, {1'b0, 16'h5a3c});
    apply("R7", 16'hffff, '0, 1'b0, {1'b0, 16'hffff});
    apply("R8", '1, '1, 1'b1, {1'b1, 16'hffff});
    apply("R3", 16'hc3a5, ~16'hc3a5, 1'b0, {1'b0, 16'hffff});
    apply("R3", 16'hc3a5, ~16'hc3a5, 1'b1, {1'b1, 16'h0000});
    apply("R4", '1, '0, 1'b1, {1'b1, 16'h0000});
    apply("R2", '1, 16'h0001, 1'b0, {1'b1, 16'h0000});
    apply("R2", 16'h7fff, 16'h0000, 1'b1, {1'b0, 16'h8000});
    apply("R2", 16'h00ff, 16'h0000, 1'b1, {1'b0, 16'h0100});
    apply("R4", 16'h8000, 16'h8000, 1'b0, {1'b1, 16'h0000});
    for (int i = 0; i < W; i++) begin
      x = 16'hffff >> (W - 1 - i);
      apply("R2", x, '0, 1'b1, ref_add(x, '0, 1'b1));
    end
    for (int n = 0; n < 400; n++) begin
      x = W'($urandom);
      y = W'($urandom);
      c = 1'($urandom);
      if (n % 8 == 0) y = ~x;
      apply("R1", x, y, c, ref_add(x, y, c));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule